// File: doc/BRIEF.md
# Video Processor CPU Register Port

This block is the processor-side register bank of a tile-based video engine. The CPU picks one of eight registers with a 3-bit select taken from the low bits of its address, so the eight registers repeat every eight bytes of the CPU window. The block holds the control, mask and vertical-blank state, the sprite attribute memory and its pointer, and the two scroll bytes. It also holds a 16-bit video address that the CPU loads in two writes.

The video data register moves bytes to or from one of three places, chosen by the current video address. Addresses below 0x2000 go to an external pattern memory through a request/valid handshake, and the block stalls while that handshake is open. Addresses up to 0x3EFF go to 2 KB of internal nametable RAM, folded by a selectable mirroring mode. Addresses at 0x3F00 and above go to a 32-byte palette RAM. Reads outside the palette return a delayed buffer.

A separate frame timing block drives the vertical-blank start and end pulses and the two sprite status bits. This block turns those pulses, together with the interrupt enable bit, into a one-cycle NMI request.

Top module: `video_reg_port`

## Requirements
- R1: After reset, cpuRdata, cpuRvalid, cpuBusy, nmiReq, ctrlOut, maskOut, scrollX, scrollY and patReq are all zero.
- R2: A read of select 0, 1, 3, 5 or 6 gives cpuRvalid with cpuRdata = 0 one cycle later. A write to select 2 changes nothing.
- R3: A read of select 2 returns {vblank, sprHitIn, sprOvfIn, 5'b0} (vblank in bit 7). It then clears vblank and returns both the scroll toggle and the address toggle to their first-write state.
- R4: Select-5 writes alternate: the first loads scrollX and the next loads scrollY.
- R5: Select-6 writes alternate: the first loads the address high byte and the next loads the low byte. The effective video address is the 16-bit address masked to 14 bits.
- R6: Every select-7 access advances the 16-bit address by 1, or by 32 when control bit 2 is set, with the carry running from the low byte into the high byte.
- R7: A select-7 read below 0x3F00 returns the buffer contents. It then reloads the buffer from the addressed byte.
- R8: A select-7 access at or above 0x3F00 uses palette index = address mod 32, with 0x10/0x14/0x18/0x1C aliased to 0x00/0x04/0x08/0x0C. A palette read returns the byte directly and leaves the buffer untouched.
- R9: Addresses 0x3000 to 0x3EFF reach the same nametable bytes as the addresses 0x1000 lower.
- R10: The 12-bit nametable offset is folded by mirrorMode. In mode 0, tables 1 and 2 land on RAM page 0 and page 1 respectively, and table 3 lands on page 1. In mode 1, tables 2 and 3 move down by 0x800. In mode 2, the offset is taken mod 0x400. In mode 3, the offset is taken mod 0x800.
- R11: A select-7 access below 0x2000 raises patReq, with patAddr, patWe and patWdata held until patValid. cpuBusy is high meanwhile. A read's cpuRvalid arrives in the cycle after patValid, with the old buffer contents, and the buffer takes patRdata.
- R12: A select-4 write stores at the sprite pointer and then increments it. A select-4 read returns the byte at the pointer and does not move it.
- R13: A control write that takes bit 7 from 0 to 1 while vblank is set gives a one-cycle nmiReq in the next cycle.
- R14: vblankSetIn sets vblank and, with control bit 7 set, gives a one-cycle nmiReq in the next cycle. vblankClrIn clears vblank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuSel | input | 3 | Register select (CPU address mod 8) |
| cpuWr | input | 1 | Write strobe, one cycle |
| cpuRd | input | 1 | Read strobe, one cycle |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data, valid with cpuRvalid |
| cpuRvalid | output | 1 | Read response pulse |
| cpuBusy | output | 1 | Pattern access open; strobes ignored |
| mirrorMode | input | 2 | Nametable folding mode 0..3 |
| vblankSetIn | input | 1 | Vertical blank start pulse |
| vblankClrIn | input | 1 | Vertical blank end pulse |
| sprHitIn | input | 1 | Sprite-zero hit status bit |
| sprOvfIn | input | 1 | Sprite overflow status bit |
| nmiReq | output | 1 | NMI request pulse |
| ctrlOut | output | 8 | Control register |
| maskOut | output | 8 | Mask register |
| scrollX | output | 8 | Horizontal scroll |
| scrollY | output | 8 | Vertical scroll |
| patReq | output | 1 | Pattern memory request |
| patWe | output | 1 | Pattern memory write enable |
| patAddr | output | 13 | Pattern memory address |
| patWdata | output | 8 | Pattern memory write data |
| patRdata | input | 8 | Pattern memory read data |
| patValid | input | 1 | Pattern memory completion |

## Verification
A register write shows on ctrlOut, maskOut, scrollX and scrollY one cycle after the clock edge that samples the strobe. An nmiReq caused by a control write or a vblankSetIn pulse comes in that same following cycle. Reads from internal storage return cpuRvalid one cycle after the strobe. Pattern-memory reads return it one cycle after the edge that samples patValid, so the delay is the handshake latency plus one.

The bench drives on falling edges and compares against a behavioural model 1 ns after every rising edge. For read responses it waits on cpuRvalid, and it checks that a pattern read waited at least the responder's latency.

// File: rtl/vrp_pkg.sv
package vrp_pkg;
  localparam int DW = 8;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0, SEL_MASK = 3'd1, SEL_STAT = 3'd2, SEL_OADR = 3'd3,
    SEL_ODAT = 3'd4, SEL_SCRL = 3'd5, SEL_VADR = 3'd6, SEL_VDAT = 3'd7
  } regSel_e;

  typedef enum logic [1:0] {
    MIR_HORZ = 2'd0, MIR_VERT = 2'd1, MIR_SINGLE = 2'd2, MIR_FOUR = 2'd3
  } mirror_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrOamAddr;
    logic wrOamData;
    logic wrScrollX;
    logic wrScrollY;
    logic wrAddrHi;
    logic wrAddrLo;
    logic dataWr;
    logic dataRd;
    logic rdStatus;
    logic rdOam;
    logic rdZero;
    logic patFill;
  } strobe_t;
endpackage

// File: rtl/vrp_ctrl.sv
module vrp_ctrl
  import vrp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] cpuSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic       wdataMsb,
  input  logic       isPat,
  input  logic       patValid,
  input  logic       nmiEn,
  input  logic       vblank,
  input  logic       vblankSetIn,
  output strobe_t    st,
  output logic       patReq,
  output logic       cpuRvalid,
  output logic       nmiReq
);
  regSel_e sel;
  logic    scrollPhase, addrPhase, pendRd, accWr, accRd;

  assign sel   = regSel_e'(cpuSel);
  assign accWr = cpuWr & ~patReq;
  assign accRd = cpuRd & ~cpuWr & ~patReq;

  always_comb begin
    st = '0;
    if (accWr) begin
      case (sel)
        SEL_CTRL: st.wrCtrl    = 1'b1;
        SEL_MASK: st.wrMask    = 1'b1;
        SEL_OADR: st.wrOamAddr = 1'b1;
        SEL_ODAT: st.wrOamData = 1'b1;
        SEL_SCRL: begin st.wrScrollY = scrollPhase; st.wrScrollX = ~scrollPhase; end
        SEL_VADR: begin st.wrAddrLo = addrPhase; st.wrAddrHi = ~addrPhase; end
        SEL_VDAT: st.dataWr    = 1'b1;
        default: ;
      endcase
    end
    if (accRd) begin
      case (sel)
        SEL_STAT: st.rdStatus = 1'b1;
        SEL_ODAT: st.rdOam    = 1'b1;
        SEL_VDAT: st.dataRd   = 1'b1;
        default:  st.rdZero   = 1'b1;
      endcase
    end
    st.patFill = patReq & patValid & pendRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scrollPhase <= 1'b0;
      addrPhase   <= 1'b0;
      patReq      <= 1'b0;
      pendRd      <= 1'b0;
      cpuRvalid   <= 1'b0;
      nmiReq      <= 1'b0;
    end else begin
      if (st.rdStatus) begin
        scrollPhase <= 1'b0;
        addrPhase   <= 1'b0;
      end else begin
        if (st.wrScrollX | st.wrScrollY) scrollPhase <= ~scrollPhase;
        if (st.wrAddrHi | st.wrAddrLo)   addrPhase   <= ~addrPhase;
      end
      if (patReq) begin
        if (patValid) patReq <= 1'b0;
      end else if ((st.dataRd | st.dataWr) & isPat) begin
        patReq <= 1'b1;
        pendRd <= st.dataRd;
      end
      cpuRvalid <= (accRd & ~((sel == SEL_VDAT) & isPat)) | st.patFill;
      nmiReq    <= (st.wrCtrl & ~nmiEn & wdataMsb & vblank) | (vblankSetIn & nmiEn);
    end
  end
endmodule

// File: rtl/vrp_data.sv
module vrp_data
  import vrp_pkg::*;
#(
  parameter int TBL_AW  = 10,
  parameter int PAL_AW  = 5,
  parameter int OAM_AW  = 8,
  parameter int VADDR_W = 14,
  parameter int PAT_AW  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DW-1:0]     cpuWdata,
  input  logic [1:0]        mirrorMode,
  input  logic              vblankSetIn,
  input  logic              vblankClrIn,
  input  logic              sprHitIn,
  input  logic              sprOvfIn,
  input  logic [DW-1:0]     patRdata,
  output logic [DW-1:0]     cpuRdata,
  output logic              isPat,
  output logic              nmiEn,
  output logic              vblank,
  output logic [DW-1:0]     ctrlOut,
  output logic [DW-1:0]     maskOut,
  output logic [DW-1:0]     scrollX,
  output logic [DW-1:0]     scrollY,
  output logic [PAT_AW-1:0] patAddr,
  output logic [DW-1:0]     patWdata,
  output logic              patWe
);
  localparam int NT_AW     = TBL_AW + 1;
  localparam int NT_BYTES  = 1 << NT_AW;
  localparam int PAL_BYTES = 1 << PAL_AW;
  localparam int OAM_BYTES = 1 << OAM_AW;

  logic [DW-1:0]      ntMem  [NT_BYTES];
  logic [DW-1:0]      palMem [PAL_BYTES];
  logic [DW-1:0]      oamMem [OAM_BYTES];
  logic [2*DW-1:0]    addrWord, addrNext;
  logic [VADDR_W-1:0] vaddr;
  logic [NT_AW:0]     ntOff;
  logic [NT_AW-1:0]   ntIdx;
  logic [PAL_AW-1:0]  palIdx;
  logic [OAM_AW-1:0]  oamAddr;
  logic [DW-1:0]      rdBuf;
  logic               isPal, isNt;
  mirror_e            mir;

  assign mir    = mirror_e'(mirrorMode);
  assign vaddr  = addrWord[VADDR_W-1:0];
  assign isPat  = (vaddr[VADDR_W-1:PAT_AW] == '0);
  assign isPal  = &vaddr[VADDR_W-1:8];
  assign isNt   = ~isPat & ~isPal;
  assign ntOff  = vaddr[NT_AW:0];
  assign nmiEn  = ctrlOut[DW-1];
  assign addrNext = addrWord + (ctrlOut[2] ? (2*DW)'(32) : (2*DW)'(1));

  always_comb begin
    case (mir)
      MIR_HORZ:   ntIdx = {ntOff[NT_AW], ntOff[TBL_AW-1:0]};
      MIR_VERT:   ntIdx = {ntOff[TBL_AW], ntOff[TBL_AW-1:0]};
      MIR_SINGLE: ntIdx = {1'b0, ntOff[TBL_AW-1:0]};
      default:    ntIdx = ntOff[NT_AW-1:0];
    endcase
    palIdx = vaddr[PAL_AW-1:0];
    if (palIdx[1:0] == 2'b00) palIdx[PAL_AW-1] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlOut <= '0; maskOut <= '0; scrollX <= '0; scrollY <= '0;
      addrWord <= '0; oamAddr <= '0; rdBuf <= '0; cpuRdata <= '0;
      vblank <= 1'b0; patAddr <= '0; patWdata <= '0; patWe <= 1'b0;
    end else begin
      if (st.wrCtrl)    ctrlOut <= cpuWdata;
      if (st.wrMask)    maskOut <= cpuWdata;
      if (st.wrScrollX) scrollX <= cpuWdata;
      if (st.wrScrollY) scrollY <= cpuWdata;
      if (st.wrAddrHi)  addrWord[2*DW-1:DW] <= cpuWdata;
      if (st.wrAddrLo)  addrWord[DW-1:0]    <= cpuWdata;
      if (st.wrOamAddr)      oamAddr <= cpuWdata[OAM_AW-1:0];
      else if (st.wrOamData) oamAddr <= oamAddr + 1'b1;
      if (st.dataRd | st.dataWr) begin
        addrWord <= addrNext;
        if (isPat) begin
          patAddr  <= vaddr[PAT_AW-1:0];
          patWdata <= cpuWdata;
          patWe    <= st.dataWr;
        end
      end
      if (vblankSetIn)                     vblank <= 1'b1;
      else if (vblankClrIn | st.rdStatus)  vblank <= 1'b0;
      if (st.rdStatus)                 cpuRdata <= {vblank, sprHitIn, sprOvfIn, {(DW-3){1'b0}}};
      else if (st.rdOam)               cpuRdata <= oamMem[oamAddr];
      else if (st.rdZero)              cpuRdata <= '0;
      else if (st.dataRd & ~isPat)     cpuRdata <= isPal ? palMem[palIdx] : rdBuf;
      else if (st.patFill)             cpuRdata <= rdBuf;
      if (st.dataRd & isNt)            rdBuf <= ntMem[ntIdx];
      else if (st.patFill)             rdBuf <= patRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (st.dataWr & isNt)  ntMem[ntIdx]    <= cpuWdata;
    if (st.dataWr & isPal) palMem[palIdx]  <= cpuWdata;
    if (st.wrOamData)      oamMem[oamAddr] <= cpuWdata;
  end
endmodule

// File: rtl/video_reg_port.sv
module video_reg_port
  import vrp_pkg::*;
#(
  parameter int TBL_AW = 10,
  parameter int PAT_AW = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cpuSel,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [7:0]        cpuWdata,
  output logic [7:0]        cpuRdata,
  output logic              cpuRvalid,
  output logic              cpuBusy,
  input  logic [1:0]        mirrorMode,
  input  logic              vblankSetIn,
  input  logic              vblankClrIn,
  input  logic              sprHitIn,
  input  logic              sprOvfIn,
  output logic              nmiReq,
  output logic [7:0]        ctrlOut,
  output logic [7:0]        maskOut,
  output logic [7:0]        scrollX,
  output logic [7:0]        scrollY,
  output logic              patReq,
  output logic              patWe,
  output logic [PAT_AW-1:0] patAddr,
  output logic [7:0]        patWdata,
  input  logic [7:0]        patRdata,
  input  logic              patValid
);
  strobe_t st;
  logic    isPat, nmiEn, vblank;

  assign cpuBusy = patReq;

  vrp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .wdataMsb(cpuWdata[7]), .isPat(isPat), .patValid(patValid), .nmiEn(nmiEn),
    .vblank(vblank), .vblankSetIn(vblankSetIn), .st(st), .patReq(patReq),
    .cpuRvalid(cpuRvalid), .nmiReq(nmiReq)
  );

  vrp_data #(.TBL_AW(TBL_AW), .PAT_AW(PAT_AW)) u_data (
    .clk(clk), .rstN(rstN), .st(st), .cpuWdata(cpuWdata), .mirrorMode(mirrorMode),
    .vblankSetIn(vblankSetIn), .vblankClrIn(vblankClrIn), .sprHitIn(sprHitIn),
    .sprOvfIn(sprOvfIn), .patRdata(patRdata), .cpuRdata(cpuRdata), .isPat(isPat),
    .nmiEn(nmiEn), .vblank(vblank), .ctrlOut(ctrlOut), .maskOut(maskOut),
    .scrollX(scrollX), .scrollY(scrollY), .patAddr(patAddr), .patWdata(patWdata),
    .patWe(patWe)
  );
endmodule

// File: rtl/video_reg_port_chk.sv
module video_reg_port_chk #(
  parameter int PAT_AW = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        cpuSel,
  input logic              cpuWr,
  input logic              cpuRd,
  input logic [7:0]        cpuWdata,
  input logic [7:0]        cpuRdata,
  input logic              cpuRvalid,
  input logic              cpuBusy,
  input logic              vblankSetIn,
  input logic              nmiReq,
  input logic [7:0]        scrollX,
  input logic [7:0]        scrollY,
  input logic              patReq,
  input logic              patValid,
  input logic [PAT_AW-1:0] patAddr
);
  // R2
  wrongdir_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !cpuWr && !cpuBusy && (cpuSel inside {3'd0, 3'd1, 3'd3, 3'd5, 3'd6}))
      |=> (cpuRvalid && cpuRdata == 8'd0));

  // R4
  scroll_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuSel == 3'd5 && !cpuBusy)
      |=> (scrollX == $past(cpuWdata) || scrollY == $past(cpuWdata)));

  // R11
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (patReq && !patValid) |=> (patReq && $stable(patAddr)));

  // R11
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuRvalid |-> !patReq);

  // R13
  nmi_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> ($past(vblankSetIn) || $past(cpuWr && cpuSel == 3'd0 && cpuWdata[7])));
endmodule

bind video_reg_port video_reg_port_chk #(.PAT_AW(PAT_AW)) u_chk (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
  .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuRvalid(cpuRvalid), .cpuBusy(cpuBusy),
  .vblankSetIn(vblankSetIn), .nmiReq(nmiReq), .scrollX(scrollX), .scrollY(scrollY),
  .patReq(patReq), .patValid(patValid), .patAddr(patAddr)
);

// File: tb/tb_video_reg_port.sv
`timescale 1ns/1ps
module tb_video_reg_port;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cpuSel = '0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0;
  logic [7:0]  cpuWdata = '0;
  logic [7:0]  cpuRdata;
  logic        cpuRvalid, cpuBusy, nmiReq, patReq, patWe;
  logic [1:0]  mirrorMode = 2'd3;
  logic        vblankSetIn = 1'b0, vblankClrIn = 1'b0, sprHitIn = 1'b1, sprOvfIn = 1'b0;
  logic [7:0]  ctrlOut, maskOut, scrollX, scrollY, patWdata;
  logic [12:0] patAddr;
  logic [7:0]  patRdata = '0;
  logic        patValid = 1'b0;

  video_reg_port dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, patCnt = 0, lastWait = 0;
  logic [7:0] patMem [8192];
  logic [7:0] mNt [2048];
  logic [7:0] mPal [32];
  logic [7:0] mOam [256];
  logic [7:0] mCtrl = 0, mScrX = 0, mScrY = 0, mBuf = 0, mOamAddr = 0;
  logic [15:0] mAddr = 0;
  logic mVbl = 0, mScrTog = 0, mAddrTog = 0, nmiExp = 0;
  int mMir = 3;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // external pattern memory with fixed latency
  always @(negedge clk) begin
    if (patReq && !patValid) begin
      patCnt++;
      if (patCnt == LAT) begin
        patValid = 1'b1;
        patRdata = patMem[patAddr];
        if (patWe) patMem[patAddr] = patWdata;
      end
    end else begin
      patValid = 1'b0;
      patCnt = 0;
    end
  end

  // per-clock comparison against the model
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      chk(nmiReq === nmiExp, "R13 nmi pulse", nmiReq, nmiExp);
      chk(scrollX === mScrX, "R4 scrollX", scrollX, mScrX);
      chk(scrollY === mScrY, "R4 scrollY", scrollY, mScrY);
      chk(ctrlOut === mCtrl, "R13 ctrl", ctrlOut, mCtrl);
    end
  end

  function automatic int ntMap(input int a);
    int off, t;
    if (a >= 'h3000) a = a - 'h1000;
    off = a - 'h2000;
    t = off / 1024;
    case (mMir)
      0: begin if (t == 1 || t == 2) off -= 1024; else if (t == 3) off -= 2048; end
      1: begin if (t >= 2) off -= 2048; end
      2: off = off % 1024;
      default: off = off % 2048;
    endcase
    return off;
  endfunction

  function automatic int palIx(input int a);
    int p;
    p = a % 32;
    if (p >= 16 && p % 4 == 0) p -= 16;
    return p;
  endfunction

  function automatic int stepAddr(input int a);
    int a14;
    a14 = a & 'h3FFF;
    mAddr = 16'((mAddr + (mCtrl[2] ? 32 : 1)) & 'hFFFF);
    return a14;
  endfunction

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    int a;
    case (sel)
      3'd0: begin nmiExp = (!mCtrl[7] && d[7] && mVbl); mCtrl = d; end
      3'd3: mOamAddr = d;
      3'd4: begin mOam[mOamAddr] = d; mOamAddr = mOamAddr + 8'd1; end
      3'd5: begin if (mScrTog) mScrY = d; else mScrX = d; mScrTog = !mScrTog; end
      3'd6: begin
        if (mAddrTog) mAddr[7:0] = d; else mAddr[15:8] = d;
        mAddrTog = !mAddrTog;
      end
      3'd7: begin
        a = stepAddr(mAddr);
        if (a >= 'h3F00) mPal[palIx(a)] = d;
        else if (a >= 'h2000) mNt[ntMap(a)] = d;
      end
      default: ;
    endcase
    cpuSel = sel; cpuWdata = d; cpuWr = 1'b1;
    @(negedge clk);
    cpuWr = 1'b0; nmiExp = 1'b0;
    while (cpuBusy) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] sel, input string tag);
    logic [7:0] exp;
    int a, n;
    exp = 8'd0;
    case (sel)
      3'd2: begin exp = {mVbl, sprHitIn, sprOvfIn, 5'b0}; mVbl = 0; mScrTog = 0; mAddrTog = 0; end
      3'd4: exp = mOam[mOamAddr];
      3'd7: begin
        a = stepAddr(mAddr);
        if (a >= 'h3F00) exp = mPal[palIx(a)];
        else begin
          exp = mBuf;
          mBuf = (a >= 'h2000) ? mNt[ntMap(a)] : patMem[a];
        end
      end
      default: exp = 8'd0;
    endcase
    cpuSel = sel; cpuRd = 1'b1;
    @(negedge clk);
    cpuRd = 1'b0;
    n = 0;
    while (!cpuRvalid && n < 100) begin @(negedge clk); n++; end
    lastWait = n;
    chk(cpuRvalid === 1'b1 && cpuRdata === exp, tag, cpuRdata, exp);
  endtask

  task automatic setAddr(input int a);
    wr(3'd6, 8'(a >> 8));
    wr(3'd6, 8'(a));
  endtask

  task automatic vblPulse();
    vblankSetIn = 1'b1; nmiExp = mCtrl[7]; mVbl = 1'b1;
    @(negedge clk);
    vblankSetIn = 1'b0; nmiExp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) patMem[i] = 8'((i * 7 + 3) & 255);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cpuRdata === 0 && cpuRvalid === 0, "R1 read side", cpuRdata, 0);
    chk(cpuBusy === 0 && nmiReq === 0 && patReq === 0, "R1 control", {cpuBusy, nmiReq, patReq}, 0);
    chk(ctrlOut === 0 && maskOut === 0 && scrollX === 0 && scrollY === 0, "R1 regs", ctrlOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    // preload nametable, palette and sprite memory
    mirrorMode = 2'd3; mMir = 3;
    setAddr('h2000);
    for (int i = 0; i < 2048; i++) wr(3'd7, 8'((i * 13 + 7) & 255));
    setAddr('h3F00);
    for (int i = 0; i < 32; i++) wr(3'd7, 8'(i ^ 8'h5A));
    wr(3'd3, 8'd0);
    for (int i = 0; i < 256; i++) wr(3'd4, 8'((i * 3) & 255));

    // R2 wrong-direction accesses
    rd(3'd0, "R2 sel0"); rd(3'd1, "R2 sel1"); rd(3'd3, "R2 sel3");
    rd(3'd5, "R2 sel5"); rd(3'd6, "R2 sel6");
    wr(3'd2, 8'hFF);
    rd(3'd2, "R2 status after write");
    wr(3'd1, 8'h1E);
    chk(maskOut === 8'h1E, "R2 mask write", maskOut, 8'h1E);

    // R13 / R14 / R3 interrupt and status behaviour
    vblPulse();
    wr(3'd0, 8'h80);
    wr(3'd0, 8'h80);
    rd(3'd2, "R3 status vblank set");
    rd(3'd2, "R3 status vblank cleared");
    vblPulse();
    rd(3'd2, "R14 status after set");
    vblPulse();
    vblankClrIn = 1'b1; mVbl = 1'b0;
    @(negedge clk);
    vblankClrIn = 1'b0;
    rd(3'd2, "R14 status after clear");
    wr(3'd0, 8'h00);

    // R4 scroll toggle, R3 toggle reset
    wr(3'd5, 8'h12); wr(3'd5, 8'h34);
    chk(scrollX === 8'h12 && scrollY === 8'h34, "R4 pair", {scrollX, scrollY}, 16'h1234);
    wr(3'd5, 8'h56);
    rd(3'd2, "R3 status");
    wr(3'd5, 8'h78);
    chk(scrollX === 8'h78, "R3 scroll toggle reset", scrollX, 8'h78);
    wr(3'd6, 8'h21);
    rd(3'd2, "R3 status");
    setAddr('h2044); wr(3'd7, 8'hC3);
    setAddr('h2044); rd(3'd7, "R3 addr toggle reset stale"); rd(3'd7, "R3 addr toggle reset");

    // R7 buffered reads
    setAddr('h2040); wr(3'd7, 8'h11); wr(3'd7, 8'h22);
    setAddr('h2040);
    rd(3'd7, "R7 stale"); rd(3'd7, "R7 first"); rd(3'd7, "R7 second");

    // R6 increments
    wr(3'd0, 8'h04);
    setAddr('h20F0); wr(3'd7, 8'h31); wr(3'd7, 8'h32);
    wr(3'd0, 8'h00);
    setAddr('h2110); rd(3'd7, "R6 stale"); rd(3'd7, "R6 step32 carry");
    setAddr('h21FF); wr(3'd7, 8'h41); wr(3'd7, 8'h42);
    setAddr('h2200); rd(3'd7, "R6 stale"); rd(3'd7, "R6 step1 carry");

    // R5 14-bit mask
    setAddr('h6305); wr(3'd7, 8'h77);
    setAddr('h2305); rd(3'd7, "R5 stale"); rd(3'd7, "R5 masked");

    // R9 fold
    setAddr('h3123); wr(3'd7, 8'h5C);
    setAddr('h2123); rd(3'd7, "R9 stale"); rd(3'd7, "R9 folded");
    setAddr('h3EF0); rd(3'd7, "R9 stale"); rd(3'd7, "R9 high fold");

    // R10 mirroring modes
    for (int m = 0; m < 4; m++) begin
      mirrorMode = 2'(m); mMir = m;
      for (int t = 0; t < 4; t++) begin
        setAddr('h2000 + t * 'h400 + 5 + m);
        wr(3'd7, 8'(8'h40 + m * 4 + t));
      end
      for (int t = 0; t < 4; t++) begin
        setAddr('h2000 + t * 'h400 + 5 + m);
        rd(3'd7, "R10 stale"); rd(3'd7, "R10 mirror");
      end
    end

    // R8 palette
    setAddr('h2040); rd(3'd7, "R7 prime");
    setAddr('h3F10); wr(3'd7, 8'h2A);
    setAddr('h3F00); rd(3'd7, "R8 alias 10->00 direct");
    setAddr('h3F34); wr(3'd7, 8'h15);
    setAddr('h3F14); rd(3'd7, "R8 mod32 alias");
    setAddr('h3F25); rd(3'd7, "R8 mod32");
    setAddr('h2041); rd(3'd7, "R8 buffer untouched");

    // R11 pattern memory
    setAddr('h0100); wr(3'd7, 8'hA5); wr(3'd7, 8'h5A);
    chk(patMem['h100] === 8'hA5, "R11 pattern write", patMem['h100], 8'hA5);
    setAddr('h0100);
    rd(3'd7, "R11 stale");
    chk(lastWait >= LAT, "R11 response after valid", lastWait, LAT);
    rd(3'd7, "R11 first"); rd(3'd7, "R11 second");

    // R12 sprite memory
    wr(3'd3, 8'h10); wr(3'd4, 8'hAA); wr(3'd4, 8'hBB);
    wr(3'd3, 8'h10); rd(3'd4, "R12 read"); rd(3'd4, "R12 no increment");
    wr(3'd3, 8'h11); rd(3'd4, "R12 next");

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule